// File: doc/BRIEF.md
# Synthesizer Reference Divider with Transmit-Gated Half-Rate Stage

This block takes the 5.12 MHz master clock of a channel synthesizer and produces the phase-comparison reference as a single-cycle pulse. The base chain divides by 1024, which gives a 5 kHz reference. An extra halving stage can stretch each reference period to 2048 input cycles, which gives 2.5 kHz. In normal wiring the halving stage follows a transmit control line, so it runs only while transmitting. A strap input can force it on permanently.

A separate divide-by-4 output, 1.28 MHz at the nominal input rate, feeds the transmit offset mixer chain. It runs continuously, whatever the reference ratio. A status output reports which ratio the current reference period is using. The ratio only changes at a period boundary, so switching never produces a short period or a runt pulse.

Top module: `synth_ref_divider`

## Requirements
- R1: A synchronous active-high `rst` clears all stages: while it is held and in the cycle after, `ref_pulse`, `ratio_ext` and `tap_clk` are 0. The first `ref_pulse` after release comes BASE_DIV cycles after the last reset cycle.
- R2: `ref_pulse` is high for exactly one input-clock cycle per reference period, and never in two consecutive cycles.
- R3: When `ratio_ext` is 0 for a period, the next `ref_pulse` comes exactly BASE_DIV (1024) cycles after the one that opened that period.
- R4: When `ratio_ext` is 1 for a period, the next `ref_pulse` comes exactly 2*BASE_DIV (2048) cycles after the one that opened that period.
- R5: With `strap_always` = 0, the ratio taken at a boundary is extended (`ratio_ext` = 1) exactly when `tx_active` = 1 at that boundary clock edge.
- R6: With `strap_always` = 1 at a boundary edge, the extended ratio is taken whatever the value of `tx_active`.
- R7: `ratio_ext` changes only in the cycle in which `ref_pulse` is high. Changes on `tx_active` or `strap_always` between boundaries have no effect on the current period's length.
- R8: `tap_clk` is a square wave of period TAP_DIV (4) cycles, low for 2 cycles and then high for 2, starting low at reset. It does not depend on the ratio or on the control inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 5.12 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_active | input | 1 | Transmit state; requests the halving stage when the strap is off |
| strap_always | input | 1 | Strap that keeps the halving stage on at all times |
| ref_pulse | output | 1 | One-cycle reference pulse, once per reference period |
| tap_clk | output | 1 | Divide-by-TAP_DIV square wave for the offset mixer |
| ratio_ext | output | 1 | 1 when the current period uses 2*BASE_DIV, 0 for BASE_DIV |

## Verification
The bench builds the block with its default BASE_DIV of 1024 and TAP_DIV of 4. At these values every period lasts at most 2048 cycles, so several dozen full periods of both ratios fit in the run. This puts transmit toggles in reach that land on the boundary edge itself, one cycle before it and one cycle after it, along with strap changes, mid-run resets and continuous phase checks of the tap against reset.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  typedef enum logic {
    RATIO_BASE = 1'b0,
    RATIO_EXT  = 1'b1
  } ratio_e;
endpackage

// File: rtl/refdiv_ratio_latch.sv
// Holds the ratio for the running reference period; reloads only at wrap.
module refdiv_ratio_latch
  import refdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tx_active,
  input  logic   strap_always,
  input  logic   wrap,
  output ratio_e sel
);
  logic want_ext;

  always_comb want_ext = strap_always | tx_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= RATIO_BASE;
    end else if (wrap) begin
      sel <= want_ext ? RATIO_EXT : RATIO_BASE;
    end
  end
endmodule

// File: rtl/refdiv_counter.sv
// Main reference counter: terminal count depends on the latched ratio.
module refdiv_counter
  import refdiv_pkg::*;
#(
  parameter int BASE_DIV = 1024
) (
  input  logic   clk,
  input  logic   rst,
  input  ratio_e sel,
  output logic   wrap,
  output logic   pulse
);
  localparam int EXT_DIV = 2 * BASE_DIV;
  localparam int CW      = $clog2(EXT_DIV);
  localparam logic [CW-1:0] LAST_BASE = CW'(BASE_DIV - 1);
  localparam logic [CW-1:0] LAST_EXT  = CW'(EXT_DIV - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb begin
    last = (sel == RATIO_EXT) ? LAST_EXT : LAST_BASE;
    wrap = (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= wrap;
      cnt   <= wrap ? '0 : cnt + CW'(1);
    end
  end
endmodule

// File: rtl/refdiv_tap.sv
// Free-running divide-by-TAP_DIV square wave, low half first.
module refdiv_tap #(
  parameter int TAP_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tap_clk
);
  localparam int TW   = (TAP_DIV > 2) ? $clog2(TAP_DIV) : 1;
  localparam int HALF = TAP_DIV / 2;
  localparam bit POW2 = ((TAP_DIV & (TAP_DIV - 1)) == 0);

  logic [TW-1:0] cnt;

  generate
    if (POW2) begin : g_pow2
      always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + TW'(1);
      end
      always_comb tap_clk = cnt[TW-1];
    end else begin : g_any
      logic tap_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt   <= '0;
          tap_q <= 1'b0;
        end else begin
          cnt   <= (cnt == TW'(TAP_DIV - 1)) ? '0 : cnt + TW'(1);
          tap_q <= (cnt >= TW'(HALF - 1)) && (cnt != TW'(TAP_DIV - 1));
        end
      end
      always_comb tap_clk = tap_q;
    end
  endgenerate
endmodule

// File: rtl/synth_ref_divider.sv
module synth_ref_divider
  import refdiv_pkg::*;
#(
  parameter int BASE_DIV = 1024,
  parameter int TAP_DIV  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_active,
  input  logic strap_always,
  output logic ref_pulse,
  output logic tap_clk,
  output logic ratio_ext
);
  ratio_e sel;
  logic   wrap;

  refdiv_ratio_latch u_ratio (
    .clk          (clk),
    .rst          (rst),
    .tx_active    (tx_active),
    .strap_always (strap_always),
    .wrap         (wrap),
    .sel          (sel)
  );

  refdiv_counter #(.BASE_DIV(BASE_DIV)) u_count (
    .clk   (clk),
    .rst   (rst),
    .sel   (sel),
    .wrap  (wrap),
    .pulse (ref_pulse)
  );

  refdiv_tap #(.TAP_DIV(TAP_DIV)) u_tap (
    .clk     (clk),
    .rst     (rst),
    .tap_clk (tap_clk)
  );

  always_comb ratio_ext = (sel == RATIO_EXT);
endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker (
  input logic clk,
  input logic rst,
  input logic tx_active,
  input logic strap_always,
  input logic ref_pulse,
  input logic tap_clk,
  input logic ratio_ext
);
  logic [1:0] seen;

  always_ff @(posedge clk) begin
    if (rst)            seen <= 2'd0;
    else if (seen != 3) seen <= seen + 2'd1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!ref_pulse && !ratio_ext && !tap_clk)); // R1

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ref_pulse |=> !ref_pulse); // R2

  AST_RATIO_FOLLOWS_TX: assert property (@(posedge clk) disable iff (rst)
    (ref_pulse && !$past(strap_always)) |-> (ratio_ext == $past(tx_active))); // R5

  AST_STRAP_FORCES: assert property (@(posedge clk) disable iff (rst)
    (ref_pulse && $past(strap_always)) |-> ratio_ext); // R6

  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ref_pulse |-> $stable(ratio_ext)); // R7

  AST_TAP_PHASE: assert property (@(posedge clk) disable iff (rst)
    (seen >= 2'd2) |-> (tap_clk != $past(tap_clk, 2))); // R8
endmodule

bind synth_ref_divider refdiv_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .tx_active    (tx_active),
  .strap_always (strap_always),
  .ref_pulse    (ref_pulse),
  .tap_clk      (tap_clk),
  .ratio_ext    (ratio_ext)
);

// File: tb/synth_ref_divider_tb_top.sv
`timescale 1ns/1ps
module synth_ref_divider_tb_top;
  localparam int BASE = 1024;
  localparam int TAPD = 4;
  localparam int RUN_CYCLES = 120000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_active = 1'b0;
  logic strap_always = 1'b0;
  logic ref_pulse, tap_clk, ratio_ext;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  synth_ref_divider #(.BASE_DIV(BASE), .TAP_DIV(TAPD)) dut_i (
    .clk(clk), .rst(rst), .tx_active(tx_active), .strap_always(strap_always),
    .ref_pulse(ref_pulse), .tap_clk(tap_clk), .ratio_ext(ratio_ext)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  function automatic int exp_interval(input bit ext);
    return ext ? 2 * BASE : BASE;
  endfunction

  function automatic bit exp_tap(input int k);
    return (k % TAPD) >= (TAPD / 2);
  endfunction

  function automatic bit exp_ratio(input bit strap, input bit tx);
    return strap | tx;
  endfunction

  initial begin
    int n = 0;
    int n0 = 0;
    int last_pulse = 0;
    bit prev_ratio = 0;
    bit prev_pulse = 0;
    bit drv_tx = 0, drv_strap = 0;
    int hold = 0;
    int rst_left = 0;
    void'($urandom(32'h5EED_0042));

    repeat (3) @(negedge clk);
    check(!ref_pulse && !ratio_ext && !tap_clk, "R1 outputs in reset", {ref_pulse, ratio_ext, tap_clk}, 0);
    rst = 1'b0;
    n0 = 0; last_pulse = 0; prev_ratio = 0; prev_pulse = 0;

    for (int cyc = 1; cyc <= RUN_CYCLES; cyc++) begin
      @(negedge clk);
      n++;
      if (rst) begin
        check(!ref_pulse && !ratio_ext && !tap_clk, "R1 outputs in reset",
              {ref_pulse, ratio_ext, tap_clk}, 0);
        rst_left--;
        if (rst_left == 0) begin
          rst = 1'b0;
          n0 = n; last_pulse = n; prev_ratio = 0; prev_pulse = 0;
        end
        continue;
      end

      // tap phase relative to the last reset cycle (R8)
      check(tap_clk == exp_tap(n - n0), "R8 tap phase", tap_clk, exp_tap(n - n0));

      if (ref_pulse) begin
        check(n - last_pulse == exp_interval(prev_ratio),
              prev_ratio ? "R4 extended interval" : (last_pulse == n0 ? "R1 first pulse" : "R3 base interval"),
              n - last_pulse, exp_interval(prev_ratio));
        check(!prev_pulse, "R2 pulse width", prev_pulse, 0);
        check(ratio_ext == exp_ratio(drv_strap, drv_tx),
              drv_strap ? "R6 strap forces ratio" : "R5 ratio from tx",
              ratio_ext, exp_ratio(drv_strap, drv_tx));
        last_pulse = n;
        prev_ratio = ratio_ext;
      end else begin
        if (ratio_ext != prev_ratio)
          check(0, "R7 ratio changed off boundary", ratio_ext, prev_ratio);
        if (n - last_pulse > exp_interval(prev_ratio))
          check(0, "R3 R4 missing pulse", n - last_pulse, exp_interval(prev_ratio));
      end
      prev_pulse = ref_pulse;

      // stimulus
      if (cyc == 60000) begin
        rst = 1'b1; rst_left = 3;
        continue;
      end
      if (cyc < 8000) begin
        drv_tx = 0; drv_strap = 0;            // R3 base only
      end else if (cyc < 16000) begin
        drv_tx = 1; drv_strap = 0;            // R4 steady transmit
      end else if (cyc < 24000) begin
        drv_strap = 0;                        // R7 toggle every cycle
        drv_tx = ~drv_tx;
      end else if (cyc < 34000) begin
        drv_strap = 1;                        // R6 strap with random tx
        if (hold == 0) begin drv_tx = 1'($urandom); hold = $urandom_range(1, 900); end
        hold--;
      end else if (n - last_pulse == exp_interval(prev_ratio) - 1 && cyc < 45000) begin
        drv_strap = 0; drv_tx = ~drv_tx;      // toggle just before the boundary edge
      end else begin
        if (hold <= 0) begin
          drv_tx = 1'($urandom);
          drv_strap = ($urandom_range(0, 7) == 0);
          hold = $urandom_range(1, 3000);
        end
        hold--;
      end
      tx_active = drv_tx;
      strap_always = drv_strap;
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(190000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule